// File: doc/BRIEF.md
# Page Write and Sequential Read Sequencer

This block runs the data phase of read and write commands for a byte-wide nonvolatile array model behind a serial memory port. A serial front end hands it whole bytes that arrive after the opcode, and a command decoder tells it which command was opened. The block collects the address bytes and then does one of two things. For a read it presents the addressed byte and steps through the array on request. For a write it gathers the data bytes of one page in a buffer.

When chip select rises, the block decides whether a page write or a status write commits. A commit happens only if the rise falls cleanly on a byte boundary. After a commit the block holds a busy period of a fixed number of system clock cycles. During the first cycles of that period it copies every page byte that was actually received into its internal array. Each byte is gated by a permit input, which the decoder evaluates for the address on `prot_addr`.

Top module: `page_seq`

## Requirements
- R1: After reset, `busy` and `sr_we` are low and every array byte reads as 0xFF.
- R2: After a command with `cmd_sel` = 1 (read) or 2 (write), the first ABYTES strobed bytes form the address, most significant byte first. The low AW bits are used. A read then presents the byte at that address on `rd_byte`.
- R3: During a read, each `rd_next` pulse advances the address by one. The address wraps from the highest location to 0.
- R4: A `cs_rise` pulse during a read ends it at once. A new command is accepted on the next cycle.
- R5: In a write, data byte k lands at the page position (start offset + k) mod PAGE. The page is the one that holds the start address. A later byte that wraps onto a position replaces the earlier one.
- R6: A write commits only if `cs_rise` arrives after at least one whole data byte and with `frag` low. Otherwise `busy` stays low and nothing is written. This covers a rise during the address bytes and a rise with no data byte.
- R7: A committed write changes only the page positions that received a byte.
- R8: After a commit, `busy` rises in the cycle after the `cs_rise` edge. It stays high for exactly BUSY_CYC cycles.
- R9: While `busy` is high, commands, bytes and `cs_rise` have no effect.
- R10: A buffered byte is written only if `prot_ok` is high while its address is shown on `prot_addr` during the copy.
- R11: A status write (`cmd_sel` = 3) commits only with exactly one data byte and `frag` low at `cs_rise`. The byte then appears on `sr_wdata` with `sr_we` high in the first busy cycle, and `busy` lasts BUSY_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cmd_go | input | 1 | Decoder pulse: a command opcode was taken |
| cmd_sel | input | 2 | Command kind: 1 read, 2 write, 3 status write |
| byte_stb | input | 1 | A whole byte after the opcode arrived |
| byte_in | input | 8 | Byte value qualified by `byte_stb` |
| frag | input | 1 | Bits of an unfinished byte have been received |
| cs_rise | input | 1 | Chip select went high |
| rd_next | input | 1 | Current read byte was shifted out; advance |
| rd_byte | output | 8 | Byte at the current read address |
| prot_addr | output | AW | Address being copied, for the permit check |
| prot_ok | input | 1 | Permit for `prot_addr` |
| sr_we | output | 1 | Status byte commit pulse |
| sr_wdata | output | 8 | Status byte to store |
| busy | output | 1 | Write cycle in progress |

## Verification
Directed cases cover several boundary conditions:
- a short write inside one page;
- a 35-byte burst that wraps within its page;
- a read that runs past the top address;
- cancelled writes ended mid-byte, ended after the address only, or ended during the address;
- a page that straddles a permit limit.

These cases separate correct wrap arithmetic, boundary detection and per-byte gating from plausible off-by-one variants. Commands injected while busy show whether the write cycle is truly closed to input. Status writes with zero, one and two bytes separate the exact-one-byte rule from a looser "at least one" rule. Seeded random page writes of random length, start and permit limit are read back and compared against a bench model of the page buffer.

// File: rtl/page_seq.sv
module page_seq #(
  parameter int AW       = 10,
  parameter int PAGE     = 32,
  parameter int ABYTES   = 2,
  parameter int BUSY_CYC = 20000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_go,
  input  logic [1:0]    cmd_sel,
  input  logic          byte_stb,
  input  logic [7:0]    byte_in,
  input  logic          frag,
  input  logic          cs_rise,
  input  logic          rd_next,
  output logic [7:0]    rd_byte,
  output logic [AW-1:0] prot_addr,
  input  logic          prot_ok,
  output logic          sr_we,
  output logic [7:0]    sr_wdata,
  output logic          busy
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = $clog2(PAGE);
  localparam int CW    = $clog2(BUSY_CYC + 1);
  localparam int AC    = $clog2(ABYTES + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_RD, S_WR, S_SR, S_BUSY} st_t;

  st_t             st;
  logic [1:0]      kind;
  logic [AC-1:0]   acnt;
  logic [AW-1:0]   abuf, a_nx, rd_addr;
  logic [AW-PW-1:0] base;
  logic [PW-1:0]   wptr, cidx;
  logic            got;
  logic [1:0]      sr_n;
  logic [CW-1:0]   bcnt;
  logic [PAGE-1:0] pval;
  logic [7:0]      pbuf [PAGE];
  logic [7:0]      mem  [DEPTH];
  logic            mem_we;

  assign a_nx      = AW'({abuf, byte_in});
  assign busy      = (st == S_BUSY);
  assign sr_we     = busy && (kind == 2'd3) && (bcnt == '0);
  assign cidx      = bcnt[PW-1:0];
  assign prot_addr = {base, cidx};
  assign mem_we    = busy && (kind == 2'd2) && (bcnt < CW'(PAGE)) && pval[cidx] && prot_ok;
  assign rd_byte   = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= '0; acnt <= '0; abuf <= '0; rd_addr <= '0;
      base <= '0; wptr <= '0; got <= 1'b0; sr_n <= '0; sr_wdata <= '0;
      bcnt <= '0; pval <= '0;
      for (int i = 0; i < PAGE; i++) pbuf[i] <= 8'h00;
    end else begin
      case (st)
        S_IDLE: if (cmd_go && cmd_sel != 2'd0) begin
          kind <= cmd_sel; pval <= '0; got <= 1'b0; sr_n <= '0; acnt <= '0;
          st <= (cmd_sel == 2'd3) ? S_SR : S_ADDR;
        end
        S_ADDR: if (cs_rise) st <= S_IDLE;
          else if (byte_stb) begin
            abuf <= a_nx;
            acnt <= acnt + 1'b1;
            if (acnt == AC'(ABYTES - 1)) begin
              if (kind == 2'd1) begin
                rd_addr <= a_nx; st <= S_RD;
              end else begin
                base <= a_nx[AW-1:PW]; wptr <= a_nx[PW-1:0]; st <= S_WR;
              end
            end
          end
        S_RD: if (cs_rise) st <= S_IDLE;
          else if (rd_next) rd_addr <= rd_addr + 1'b1;
        S_WR: if (cs_rise) begin
            st   <= (got && !frag) ? S_BUSY : S_IDLE;
            bcnt <= '0;
          end else if (byte_stb) begin
            pbuf[wptr] <= byte_in; pval[wptr] <= 1'b1;
            wptr <= wptr + 1'b1; got <= 1'b1;
          end
        S_SR: if (cs_rise) begin
            st   <= (sr_n == 2'd1 && !frag) ? S_BUSY : S_IDLE;
            bcnt <= '0;
          end else if (byte_stb) begin
            if (sr_n == 2'd0) sr_wdata <= byte_in;
            if (sr_n != 2'd2) sr_n <= sr_n + 1'b1;
          end
        S_BUSY: if (bcnt == CW'(BUSY_CYC - 1)) st <= S_IDLE;
          else bcnt <= bcnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (mem_we) begin
      mem[prot_addr] <= pbuf[cidx];
    end
  end

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bcnt != CW'(BUSY_CYC - 1)) |=> busy);
  assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bcnt == CW'(BUSY_CYC - 1)) |=> !busy);
  assert_frag_nocommit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && cs_rise && frag) |=> !busy);
  assert_rd_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD && rd_next && !cs_rise) |=> (rd_addr == AW'($past(rd_addr) + 1'b1)));
  assert_sr_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SR && cs_rise && sr_n != 2'd1) |=> !busy);
  assert_busy_deaf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_go) |=> (busy || st == S_IDLE));
endmodule

// File: tb/page_seq_tb.sv
`timescale 1ns/1ps
module page_seq_tb;
  localparam int AW = 10, PAGE = 32, ABYTES = 2, BUSY_CYC = 40, DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic cmd_go = 0, byte_stb = 0, frag = 0, cs_rise = 0, rd_next = 0;
  logic [1:0] cmd_sel = 0;
  logic [7:0] byte_in = 0;
  logic [7:0] rd_byte, sr_wdata;
  logic [AW-1:0] prot_addr;
  logic prot_ok, sr_we, busy;
  int lim = DEPTH;
  int nchk = 0, nbad = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] wd [64];

  always #5 clk = ~clk;
  assign prot_ok = (int'(prot_addr) < lim);

  page_seq #(.AW(AW), .PAGE(PAGE), .ABYTES(ABYTES), .BUSY_CYC(BUSY_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_sel(cmd_sel),
    .byte_stb(byte_stb), .byte_in(byte_in), .frag(frag), .cs_rise(cs_rise),
    .rd_next(rd_next), .rd_byte(rd_byte), .prot_addr(prot_addr), .prot_ok(prot_ok),
    .sr_we(sr_we), .sr_wdata(sr_wdata), .busy(busy));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input int k);
    cmd_go = 1; cmd_sel = 2'(k); @(negedge clk); cmd_go = 0; cmd_sel = 0;
  endtask
  task automatic putb(input int b);
    byte_stb = 1; byte_in = 8'(b); @(negedge clk); byte_stb = 0;
  endtask
  task automatic csu(input bit fr);
    cs_rise = 1; frag = fr; @(negedge clk); cs_rise = 0; frag = 0;
  endtask
  task automatic nxt;
    rd_next = 1; @(negedge clk); rd_next = 0;
  endtask
  task automatic wait_idle(output int c);
    c = 0;
    while (busy) begin c++; @(negedge clk); end
  endtask

  task automatic read_chk(input int a, input int n, input string r);
    cmd(1); putb(a >> 8); putb(a & 255);
    for (int i = 0; i < n; i++) begin
      chk(rd_byte == model[(a + i) % DEPTH], r, rd_byte, model[(a + i) % DEPTH]);
      nxt;
    end
    csu(0);
  endtask

  task automatic page_wr(input int a, input int n, input bit fr, output int c);
    logic [7:0] bd [PAGE];
    bit bv [PAGE];
    for (int i = 0; i < PAGE; i++) bv[i] = 0;
    cmd(2); putb(a >> 8); putb(a & 255);
    for (int k = 0; k < n; k++) begin
      putb(wd[k]);
      bd[(a + k) % PAGE] = wd[k]; bv[(a + k) % PAGE] = 1;
    end
    csu(fr);
    if (n > 0 && !fr)
      for (int i = 0; i < PAGE; i++) begin
        int ad = (a & ~(PAGE - 1)) | i;
        if (bv[i] && ad < lim) model[ad] = bd[i];
      end
    wait_idle(c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    int c;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(sr_we == 0, "R1 sr_we", sr_we, 0);
    read_chk(0, 4, "R1");

    wd[0] = 8'h11; wd[1] = 8'h22; wd[2] = 8'h33;
    page_wr('h045, 3, 0, c);
    chk(c == BUSY_CYC, "R8 busy length", c, BUSY_CYC);
    read_chk('h044, 5, "R2 R7");

    for (int i = 0; i < 35; i++) wd[i] = 8'(8'h80 + i);
    page_wr('h3FE, 35, 0, c);
    read_chk('h3E0, 40, "R5 R3");

    wd[0] = 8'hAB; wd[1] = 8'hCD;
    page_wr('h100, 2, 1, c);
    chk(c == 0, "R6 fragment", c, 0);
    read_chk('h100, 2, "R6");
    page_wr('h120, 0, 0, c);
    chk(c == 0, "R6 no data byte", c, 0);
    cmd(2); putb(1); csu(0);
    chk(busy == 0, "R6 rise in address", busy, 0);

    cmd(1); putb(0); putb('h45); nxt; csu(0);
    chk(busy == 0, "R4 abort", busy, 0);
    read_chk('h46, 2, "R4");

    lim = 'h210;
    for (int i = 0; i < 32; i++) wd[i] = 8'(i * 3 + 1);
    page_wr('h200, 32, 0, c);
    read_chk('h200, 32, "R10");
    lim = DEPTH;

    wd[0] = 8'h77;
    cmd(2); putb(0); putb('h60); putb(wd[0]); csu(0);
    model['h60] = 8'h77;
    chk(busy == 1, "R8 rise", busy, 1);
    cmd(2); putb(0); putb('h80); putb('h5A); csu(0); cmd(1);
    wait_idle(c);
    chk(busy == 0, "R9 idle after", busy, 0);
    read_chk('h60, 1, "R9");
    read_chk('h80, 1, "R9");

    cmd(3); putb('hA5); csu(0);
    chk(sr_we == 1 && sr_wdata == 8'hA5, "R11 commit", sr_wdata, 'hA5);
    wait_idle(c);
    chk(c == BUSY_CYC, "R11 busy length", c, BUSY_CYC);
    cmd(3); putb(1); putb(2); csu(0);
    chk(busy == 0, "R11 two bytes", busy, 0);
    cmd(3); putb(1); csu(1);
    chk(busy == 0, "R11 fragment", busy, 0);
    cmd(3); csu(0);
    chk(busy == 0 && sr_we == 0, "R11 no byte", busy, 0);

    void'($urandom(1234));
    for (int it = 0; it < 10; it++) begin
      int a = $urandom % DEPTH;
      int n = 1 + $urandom % 40;
      int pick = $urandom % 3;
      lim = (pick == 0) ? DEPTH : (pick == 1) ? 512 : (a & ~(PAGE - 1)) + 13;
      for (int i = 0; i < n; i++) wd[i] = 8'($urandom);
      page_wr(a, n, 0, c);
      chk(c == BUSY_CYC, "R8 random", c, BUSY_CYC);
      read_chk(a & ~(PAGE - 1), PAGE, "R5 R10 random");
    end
    lim = DEPTH;

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule